// File: doc/BRIEF.md
# Set-Associative Translation Cache with Refill

This block keeps a small number of recent page translations close to the requester, so that most lookups complete without touching the page table in memory. A requester presents an 8-bit virtual page number. In the same cycle the block answers with a hit flag, the physical page number and the permission bits of the matching entry. The block looks up and replaces nothing on its own.

When a requested page is not held, the block raises a miss request that carries the virtual page number to the page-walk logic. That logic later returns an entry on the refill port, and the block installs it at the next clock edge. The block also provides a flush input that discards every held translation in one cycle.

The storage is organised as 4 sets of 4 ways, which gives 16 entries. The low bits of the page number pick a set, and the remaining bits are compared as a tag. Victims are chosen per set. A free way is always used first. When the set is full, a round-robin pointer that belongs to that set picks the way to replace.

Top module: `xlat_cache`

## Requirements
- R1: The set is page-number bits [1:0] and the tag is page-number bits [7:2]. An entry hits only in its own set, so an equal tag stored in another set gives a miss.
- R2: With lookupReq high, hit is high in the same cycle only when a valid way in the selected set holds an equal tag. In that case hitPpn and hitPerm carry that way's stored values.
- R3: missReq is high exactly when lookupReq is high and there is no hit, and missVpn then equals lookupVpn. With lookupReq low, neither hit nor missReq is asserted.
- R4: A refill with refillPteValid=1 is written at the next rising edge. From the following cycle a lookup of refillVpn hits and returns the installed PPN and permission bits.
- R5: A refill with refillPteValid=0 is not installed, and a later lookup of that page number still misses.
- R6: A refill into a set that still has a free way takes the lowest-numbered free way and displaces no valid entry.
- R7: A refill into a full set replaces the way named by that set's round-robin pointer. After reset each pointer is 0, and it advances by one, wrapping, on each replacement in its own set only.
- R8: flushAll clears every valid bit at the next edge. A refill presented in the same cycle as a flush is dropped.
- R9: After reset no entry is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupReq | input | 1 | A lookup is presented this cycle |
| lookupVpn | input | 8 | Virtual page number to translate |
| hit | output | 1 | A valid matching entry was found |
| hitPpn | output | 6 | Physical page number of the hit |
| hitPerm | output | 3 | Permission bits of the hit |
| missReq | output | 1 | Request to the page walker for a missing translation |
| missVpn | output | 8 | Page number that missed |
| refillWe | input | 1 | Refill entry presented this cycle |
| refillVpn | input | 8 | Page number of the refill entry |
| refillPpn | input | 6 | Physical page number to install |
| refillPerm | input | 3 | Permission bits to install |
| refillPteValid | input | 1 | Valid bit of the returned entry; 0 blocks installation |
| flushAll | input | 1 | Invalidate every entry |

## Verification
The bench builds the block with its default values: 4 sets of 4 ways, an 8-bit page number, a 6-bit PPN and 3 permission bits. With sets this small, a set fills after four refills, and two more refills show that the round-robin pointer moves. A second set can then be filled to show that each set keeps its own pointer. The 6-bit tag width makes it possible to store the same tag in two different sets, which checks that a lookup compares only the ways of its own set.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Strobes from the control to the entry store
  typedef struct packed {
    logic wrEn;    // write the selected way this edge
    logic clrAll;  // drop every valid bit this edge
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_way_match.sv
module xlat_way_match #(
  parameter int TAG_W = 6
) (
  input  logic             entValid,
  input  logic [TAG_W-1:0] entTag,
  input  logic [TAG_W-1:0] probeTag,
  output logic             match
);
  always_comb match = entValid && (entTag == probeTag);
endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int SET_W  = 2,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 6,
  parameter int PPN_W  = 6,
  parameter int PERM_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  xlatStrobe_t             strobe,
  input  logic [SET_W-1:0]        wrSet,
  input  logic [$clog2(WAYS)-1:0] wrWay,
  input  logic [TAG_W-1:0]        wrTag,
  input  logic [PPN_W-1:0]        wrPpn,
  input  logic [PERM_W-1:0]       wrPerm,
  input  logic [SET_W-1:0]        rdSet,
  input  logic [TAG_W-1:0]        rdTag,
  output logic                    rdHit,
  output logic [PPN_W-1:0]        rdPpn,
  output logic [PERM_W-1:0]       rdPerm,
  output logic [WAYS-1:0]         wrSetValid
);
  localparam int SETS = 1 << SET_W;

  logic [WAYS-1:0]   validQ [SETS];
  logic [TAG_W-1:0]  tagQ   [SETS][WAYS];
  logic [PPN_W-1:0]  ppnQ   [SETS][WAYS];
  logic [PERM_W-1:0] permQ  [SETS][WAYS];
  logic [WAYS-1:0]   wayHit;

  // Valid bits: reset and flush clear them; flush wins over a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (strobe.clrAll) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (strobe.wrEn) begin
      validQ[wrSet][wrWay] <= 1'b1;
    end
  end

  // Entry payload, no reset needed behind the valid bits
  always_ff @(posedge clk) begin
    if (strobe.wrEn && !strobe.clrAll) begin
      tagQ[wrSet][wrWay]  <= wrTag;
      ppnQ[wrSet][wrWay]  <= wrPpn;
      permQ[wrSet][wrWay] <= wrPerm;
    end
  end

  // One comparator per way of the addressed set
  for (genvar w = 0; w < WAYS; w++) begin : gWay
    xlat_way_match #(.TAG_W(TAG_W)) uMatch (
      .entValid (validQ[rdSet][w]),
      .entTag   (tagQ[rdSet][w]),
      .probeTag (rdTag),
      .match    (wayHit[w])
    );
  end

  // Lowest matching way drives the outputs
  always_comb begin
    rdPpn  = '0;
    rdPerm = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayHit[w]) begin
        rdPpn  = ppnQ[rdSet][w];
        rdPerm = permQ[rdSet][w];
      end
    end
    rdHit = |wayHit;
  end

  always_comb wrSetValid = validQ[wrSet];

  // R8: nothing survives a flush
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> !rdHit);

  // R4: a written entry is found from the next cycle on
  a_r4_write_visible: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.clrAll) |=>
      (rdSet != $past(wrSet) || rdTag != $past(wrTag) || rdHit));
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int SET_W = 2,
  parameter int WAYS  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    refillWe,
  input  logic                    refillPteValid,
  input  logic                    flushAll,
  input  logic [SET_W-1:0]        refillSet,
  input  logic [WAYS-1:0]         setValid,
  output xlatStrobe_t             strobe,
  output logic [$clog2(WAYS)-1:0] wrWay
);
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] rrQ [SETS];
  logic [WAY_W-1:0] firstFree;
  logic             allValid;

  always_comb begin
    firstFree = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!setValid[w]) firstFree = WAY_W'(w);
    end
    allValid = &setValid;
  end

  always_comb begin
    strobe.clrAll = flushAll;
    strobe.wrEn   = refillWe && refillPteValid && !flushAll;
    wrWay         = allValid ? rrQ[refillSet] : firstFree;
  end

  // Per-set round-robin pointers, moved only by a replacement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) rrQ[s] <= '0;
    end else if (strobe.wrEn && allValid) begin
      if (rrQ[refillSet] == WAY_W'(WAYS - 1)) rrQ[refillSet] <= '0;
      else rrQ[refillSet] <= rrQ[refillSet] + WAY_W'(1);
    end
  end

  // R6: with space left, never overwrite a valid way
  a_r6_take_free_way: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !allValid) |-> !setValid[wrWay]);

  // R5: an entry marked invalid is never written
  a_r5_drop_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (refillWe && !refillPteValid) |-> !strobe.wrEn);

  // R8: a flush blocks a refill in the same cycle
  a_r8_flush_priority: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> !strobe.wrEn);

  // R7: a replacement moves the pointer of its set
  a_r7_pointer_moves: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && allValid) |=> rrQ[$past(refillSet)] != $past(rrQ[refillSet]));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VPN_W  = 8,
  parameter int SET_W  = 2,
  parameter int WAYS   = 4,
  parameter int PPN_W  = 6,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupReq,
  input  logic [VPN_W-1:0]  lookupVpn,
  output logic              hit,
  output logic [PPN_W-1:0]  hitPpn,
  output logic [PERM_W-1:0] hitPerm,
  output logic              missReq,
  output logic [VPN_W-1:0]  missVpn,
  input  logic              refillWe,
  input  logic [VPN_W-1:0]  refillVpn,
  input  logic [PPN_W-1:0]  refillPpn,
  input  logic [PERM_W-1:0] refillPerm,
  input  logic              refillPteValid,
  input  logic              flushAll
);
  localparam int TAG_W = VPN_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);

  xlatStrobe_t      strobe;
  logic [WAY_W-1:0] wrWay;
  logic [WAYS-1:0]  setValid;
  logic             rdHit;

  xlat_ctrl #(.SET_W(SET_W), .WAYS(WAYS)) uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .refillWe       (refillWe),
    .refillPteValid (refillPteValid),
    .flushAll       (flushAll),
    .refillSet      (refillVpn[SET_W-1:0]),
    .setValid       (setValid),
    .strobe         (strobe),
    .wrWay          (wrWay)
  );

  xlat_store #(
    .SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
  ) uStore (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrSet      (refillVpn[SET_W-1:0]),
    .wrWay      (wrWay),
    .wrTag      (refillVpn[VPN_W-1:SET_W]),
    .wrPpn      (refillPpn),
    .wrPerm     (refillPerm),
    .rdSet      (lookupVpn[SET_W-1:0]),
    .rdTag      (lookupVpn[VPN_W-1:SET_W]),
    .rdHit      (rdHit),
    .rdPpn      (hitPpn),
    .rdPerm     (hitPerm),
    .wrSetValid (setValid)
  );

  always_comb begin
    hit     = lookupReq && rdHit;
    missReq = lookupReq && !rdHit;
    missVpn = lookupVpn;
  end

  // R3: an idle lookup port raises nothing
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lookupReq |-> (!hit && !missReq));

  // R3: hit and miss request never together
  a_r3_hit_excludes_miss: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> !missReq);
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lookupReq = 1'b0;
  logic [7:0] lookupVpn = '0;
  logic       hit;
  logic [5:0] hitPpn;
  logic [2:0] hitPerm;
  logic       missReq;
  logic [7:0] missVpn;
  logic       refillWe = 1'b0;
  logic [7:0] refillVpn = '0;
  logic [5:0] refillPpn = '0;
  logic [2:0] refillPerm = '0;
  logic       refillPteValid = 1'b0;
  logic       flushAll = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_cache u0 (
    .clk(clk), .rstN(rstN), .lookupReq(lookupReq), .lookupVpn(lookupVpn),
    .hit(hit), .hitPpn(hitPpn), .hitPerm(hitPerm), .missReq(missReq),
    .missVpn(missVpn), .refillWe(refillWe), .refillVpn(refillVpn),
    .refillPpn(refillPpn), .refillPerm(refillPerm),
    .refillPteValid(refillPteValid), .flushAll(flushAll)
  );

  task automatic checkEq(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Lookup presented after a falling edge, sampled 1 time unit later
  task automatic probe(string req, logic [7:0] vpn, bit expHit,
                       logic [5:0] expPpn, logic [2:0] expPerm);
    @(negedge clk);
    lookupReq = 1'b1;
    lookupVpn = vpn;
    #1;
    checkEq(req, "hit", int'(hit), int'(expHit));
    checkEq(req, "missReq", int'(missReq), int'(!expHit));
    if (expHit) begin
      checkEq(req, "hitPpn", int'(hitPpn), int'(expPpn));
      checkEq(req, "hitPerm", int'(hitPerm), int'(expPerm));
    end else begin
      checkEq(req, "missVpn", int'(missVpn), int'(vpn));
    end
    lookupReq = 1'b0;
  endtask

  task automatic refill(logic [7:0] vpn, logic [5:0] ppn, logic [2:0] perm,
                        bit pteV, bit withFlush);
    @(negedge clk);
    refillWe = 1'b1;
    refillVpn = vpn;
    refillPpn = ppn;
    refillPerm = perm;
    refillPteValid = pteV;
    flushAll = withFlush;
    @(negedge clk);
    refillWe = 1'b0;
    refillPteValid = 1'b0;
    flushAll = 1'b0;
  endtask

  // R9 and R3: empty after reset, misses report the page number
  task automatic testReset();
    probe("R9", 8'h0F, 1'b0, '0, '0);
    probe("R9", 8'hA6, 1'b0, '0, '0);
  endtask

  // R1, R2, R4: set/tag split and install of one entry
  task automatic testBasic();
    refill(8'h0F, 6'h0D, 3'b101, 1'b1, 1'b0);
    probe("R4", 8'h0F, 1'b1, 6'h0D, 3'b101);
    probe("R1", 8'h2E, 1'b0, '0, '0);
    probe("R1", 8'h0C, 1'b0, '0, '0);  // tag 0x03 in set 0
    probe("R1", 8'h0E, 1'b0, '0, '0);  // tag 0x03 in set 2
    @(negedge clk);
    lookupVpn = 8'h0F;
    lookupReq = 1'b0;
    #1;
    checkEq("R3", "idle hit", int'(hit), 0);
    checkEq("R3", "idle missReq", int'(missReq), 0);
  endtask

  // R5: an entry returned as invalid is not kept
  task automatic testInvalidRefill();
    refill(8'h2E, 6'h11, 3'b010, 1'b0, 1'b0);
    probe("R5", 8'h2E, 1'b0, '0, '0);
  endtask

  // R6 and R7: fill set 0, then replace in round-robin order
  task automatic testReplace();
    for (int i = 1; i <= 4; i++)
      refill(8'(i * 16), 6'(i), 3'(i), 1'b1, 1'b0);
    for (int i = 1; i <= 4; i++)
      probe("R6", 8'(i * 16), 1'b1, 6'(i), 3'(i));
    refill(8'h50, 6'h05, 3'b101, 1'b1, 1'b0);
    probe("R7", 8'h10, 1'b0, '0, '0);
    probe("R7", 8'h50, 1'b1, 6'h05, 3'b101);
    probe("R7", 8'h20, 1'b1, 6'h02, 3'b010);
    refill(8'h60, 6'h06, 3'b110, 1'b1, 1'b0);
    probe("R7", 8'h20, 1'b0, '0, '0);
    probe("R7", 8'h30, 1'b1, 6'h03, 3'b011);
    probe("R7", 8'h0F, 1'b1, 6'h0D, 3'b101);
  endtask

  // R7: set 1 keeps its own pointer at way 0
  task automatic testPerSetPointer();
    refill(8'h01, 6'h21, 3'b001, 1'b1, 1'b0);
    refill(8'h05, 6'h22, 3'b001, 1'b1, 1'b0);
    refill(8'h09, 6'h23, 3'b001, 1'b1, 1'b0);
    refill(8'h0D, 6'h24, 3'b001, 1'b1, 1'b0);
    refill(8'h11, 6'h25, 3'b011, 1'b1, 1'b0);
    probe("R7", 8'h01, 1'b0, '0, '0);
    probe("R7", 8'h05, 1'b1, 6'h22, 3'b001);
    probe("R7", 8'h11, 1'b1, 6'h25, 3'b011);
  endtask

  // R8: flush empties everything and drops a refill in the same cycle
  task automatic testFlush();
    refill(8'h22, 6'h30, 3'b111, 1'b1, 1'b1);
    probe("R8", 8'h22, 1'b0, '0, '0);
    probe("R8", 8'h50, 1'b0, '0, '0);
    probe("R8", 8'h0F, 1'b0, '0, '0);
    probe("R8", 8'h11, 1'b0, '0, '0);
    refill(8'h0F, 6'h0D, 3'b100, 1'b1, 1'b0);
    probe("R8", 8'h0F, 1'b1, 6'h0D, 3'b100);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testInvalidRefill();
    testReplace();
    testPerSetPointer();
    testFlush();
    finishRun();
  end
endmodule